// File: doc/BRIEF.md
# Level-tracking 32-source interrupt controller

This block gathers up to 32 interrupt request lines into a status word, masks that word with a software-programmed enable word, and drives a single interrupt request toward a processor. Each status bit follows its line. A rising line sets the bit and a falling line clears it. Between line changes, software may clear bits, or it may replace the whole status word.

Software reaches the block through a simple register port with an address, a write strobe with write data, and a read strobe with combinational read data. Four word offsets are defined. Offset 0x0 is the raw status register, which is cleared by writing ones. Offset 0x4 is the status load register. Offset 0x8 is the enable mask. Offset 0xC is the masked status, which is read-only. Any other offset is an unsupported access. A read of the load register is also an unsupported access. Either kind raises a sticky error output that only reset clears.

Top module: `irq_level_agg`

## Requirements
- R1: After reset, the status and enable words are zero, `irq_o` is 0 and `err_o` is 0.
- R2: A rising edge on `src_i[i]` sets status bit i, and a falling edge clears it. The new value can be read at offset 0x0 after the next clock edge.
- R3: `irq_o` is registered. It equals the OR of (status AND enable) as held after the previous clock edge, so it follows a status or enable change by one cycle.
- R4: Writing offset 0x0 clears every status bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: Writing offset 0x4 replaces the whole status word with the write data.
- R6: Offset 0x8 holds the enable word. A write replaces it, and a read returns it.
- R7: Reading offset 0xC returns status AND enable. A write to offset 0xC changes neither status nor enable, and it does not set `err_o`.
- R8: Reading offset 0x4 returns the raw status and sets `err_o`.
- R9: A read or write at any offset other than 0x0, 0x4, 0x8 or 0xC sets `err_o`, which stays at 1 until reset. Such a read returns zero, and such a write changes no state.
- R10: If a line changes in the same cycle that a software write touches the same status bit, the bit takes the new line level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Interrupt source levels |
| addr_i | input | ADDR_W | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | NSRC | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | NSRC | Read data (combinational) |
| irq_o | output | 1 | Processor interrupt request |
| err_o | output | 1 | Sticky unsupported-access flag |

## Verification
A corrupted status or enable bit shows up one cycle later as a wrong level on `irq_o`. It also shows up at once in the read data of offset 0x0, 0x8 or 0xC. The bench walks every source line on its own, with only the matching enable bit set. It checks both the one-cycle lag of `irq_o` and the exact status word. A mis-decoded offset shows up as an early or missing rise of `err_o`, or as a nonzero read from an undefined offset. The bench also drives a line change and a write together, to check that the line wins the collision.

// File: rtl/irq_level_agg.sv
module irq_level_agg #(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [NSRC-1:0]   wdata_i,
  input  logic              rd_en_i,
  output logic [NSRC-1:0]   rdata_o,
  output logic              irq_o,
  output logic              err_o
);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFS_LOAD = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] OFS_MSTA = ADDR_W'(4'hC);

  logic [NSRC-1:0] stat_q, mask_q, src_q, sw_stat, stat_d, chg;
  logic            irq_q, err_q, known;

  assign chg   = src_i ^ src_q;
  assign known = (addr_i == OFS_STAT) || (addr_i == OFS_LOAD) ||
                 (addr_i == OFS_MASK) || (addr_i == OFS_MSTA);

  always_comb begin
    sw_stat = stat_q;
    if (wr_en_i && addr_i == OFS_STAT) sw_stat = stat_q & ~wdata_i;
    else if (wr_en_i && addr_i == OFS_LOAD) sw_stat = wdata_i;
    stat_d = (sw_stat & ~chg) | (src_i & chg);
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (addr_i)
        OFS_STAT, OFS_LOAD: rdata_o = stat_q;
        OFS_MASK:           rdata_o = mask_q;
        OFS_MSTA:           rdata_o = stat_q & mask_q;
        default:            rdata_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      src_q  <= '0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      src_q  <= src_i;
      stat_q <= stat_d;
      if (wr_en_i && addr_i == OFS_MASK) mask_q <= wdata_i;
      irq_q  <= |(stat_q & mask_q);
      if ((rd_en_i && addr_i == OFS_LOAD) || ((rd_en_i || wr_en_i) && !known))
        err_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;
  assign err_o = err_q;

  a_r3_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & mask_q) != '0) |=> irq_o);
  a_r3_irq_falls: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & mask_q) == '0) |=> !irq_o);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  a_r9_undef_no_state: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !known && chg == '0) |=> ($stable(stat_q) && $stable(mask_q)));
  a_r7_msta_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == OFS_MSTA && chg == '0) |=> ($stable(stat_q) && $stable(mask_q)));
  a_r5_load_replaces: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == OFS_LOAD && chg == '0) |=> (stat_q == $past(wdata_i)));
  a_r10_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (chg != '0) |=> ((stat_q & $past(chg)) == ($past(src_i) & $past(chg))));
endmodule

// File: tb/test_irq_level_agg.sv
module test_irq_level_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rdata_o;
  logic        irq_o, err_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  irq_level_agg i_irq_level_agg (.clk(clk), .rst_n(rst_n), .src_i(src_i),
    .addr_i(addr_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rd_en_i(rd_en_i),
    .rdata_o(rdata_o), .irq_o(irq_o), .err_o(err_o));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    tick(1);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    tick(1);
    rd_en_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; src_i = '0; wr_en_i = 1'b0; rd_en_i = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d, s_exp, e_exp;
    do_reset();
    rd(8'h0, d); chk("R1 status", d, 0);
    rd(8'h8, d); chk("R1 enable", d, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 err", err_o, 0);

    for (int i = 0; i < 32; i++) begin
      wr(8'h8, 32'h1 << i);
      src_i[i] = 1'b1;
      tick(1);
      chk("R3 irq lags status", irq_o, 0);
      tick(1);
      chk("R3 irq asserted", irq_o, 1);
      rd(8'h0, d); chk("R2 rise sets bit", d, 32'h1 << i);
      src_i[i] = 1'b0;
      tick(2);
      chk("R3 irq deasserted", irq_o, 0);
      rd(8'h0, d); chk("R2 fall clears bit", d, 0);
    end

    s_exp = 32'hA5C3_0F96; e_exp = 32'h0FF0_33CC;
    wr(8'h4, s_exp);
    rd(8'h0, d); chk("R5 load replaces", d, s_exp);
    wr(8'h8, e_exp);
    rd(8'h8, d); chk("R6 enable readback", d, e_exp);
    rd(8'hC, d); chk("R7 masked read", d, s_exp & e_exp);
    tick(1);
    chk("R3 irq from mask", irq_o, 1);
    wr(8'hC, 32'hFFFF_FFFF);
    rd(8'h0, d); chk("R7 write leaves status", d, s_exp);
    rd(8'h8, d); chk("R7 write leaves enable", d, e_exp);
    chk("R7 no error", err_o, 0);
    wr(8'h0, 32'h0000_FFFF);
    s_exp = s_exp & 32'hFFFF_0000;
    rd(8'h0, d); chk("R4 w1c", d, s_exp);
    wr(8'h8, 32'h0000_FFFF);
    tick(1);
    chk("R3 irq off when masked", irq_o, 0);
    wr(8'h0, 32'hFFFF_FFFF);
    rd(8'h0, d); chk("R4 clear all", d, 0);
    chk("R8 err before", err_o, 0);
    wr(8'h4, 32'h1234_5678);
    rd(8'h4, d); chk("R8 read returns status", d, 32'h1234_5678);
    chk("R8 err set", err_o, 1);

    do_reset();
    chk("R1 err cleared by reset", err_o, 0);
    wr(8'h4, 32'h0F0F_0F0F);
    wr(8'h8, 32'h3333_3333);
    wr(8'h10, 32'hFFFF_FFFF);
    chk("R9 err on undefined write", err_o, 1);
    rd(8'h0, d); chk("R9 status untouched", d, 32'h0F0F_0F0F);
    rd(8'h8, d); chk("R9 enable untouched", d, 32'h3333_3333);
    rd(8'h2, d); chk("R9 misaligned reads zero", d, 0);
    rd(8'hF0, d); chk("R9 undefined reads zero", d, 0);
    tick(3);
    chk("R9 err sticky", err_o, 1);

    do_reset();
    src_i[3] = 1'b1; addr_i = 8'h0; wdata_i = 32'h8; wr_en_i = 1'b1;
    tick(1); wr_en_i = 1'b0;
    rd(8'h0, d); chk("R10 rise beats w1c", d, 32'h8);
    src_i[3] = 1'b0; addr_i = 8'h4; wdata_i = 32'hFFFF_FFFF; wr_en_i = 1'b1;
    tick(1); wr_en_i = 1'b0;
    rd(8'h0, d); chk("R10 fall beats load", d, 32'hFFFF_FFF7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule